// File: doc/BRIEF.md
# Trigger Distributor With Busy Gating

This block sits between a trigger decision source and four front-end digitizer modules. Each cycle it samples one trigger request, taken either from an upstream request line or from an internal pseudo-random generator used during test runs. When it accepts a request, it raises the trigger line of every front-end in the same cycle for exactly one cycle. It then refuses further requests until the front-ends have signalled and then released their busy lines. A request that arrives while the block is refusing is dropped and counted.

Every accepted trigger also writes an entry into a small first-word-fall-through queue. The entry holds the running event number and a type code. A host drains the queue through a simple read port. A full queue blocks new triggers in the same way that an active busy line does, so no event record is ever lost. A timeout on the busy handshake keeps a front-end that never raises busy from stalling the block for good.

Top module: `trig_fanout_gate`

## Requirements
- R1: One cycle after an accepted request, all four bits of `fe_trig` are 1 for exactly one cycle. Otherwise `fe_trig` is 4'b0000.
- R2: A request made while any bit of `fe_busy` is 1, or before every busy bit has returned to 0 after a trigger, produces no trigger.
- R3: Each accepted trigger writes one queue entry of {event number, type}. The first event after reset is number 0 and each later event is one higher. External triggers carry `ext_type`.
- R4: `host_valid` is 1 whenever the queue holds an entry, and `host_evt`/`host_type` then show the oldest entry. `host_rd` with `host_valid` removes that entry at the clock edge, and entries leave in the order they arrived.
- R5: Each cycle in which the selected request is 1 but cannot be accepted increments `rej_count` by exactly one. The rejected request is not stored for later.
- R6: After a trigger, if no busy bit rises within TMO_CYC cycles of the state that follows the pulse, the block accepts requests again. With TMO_CYC = 8, a request 8 cycles after the pulse is refused and one 9 cycles after is accepted.
- R7: While the queue holds DEPTH entries (4 by default), a request is refused and counted, and no trigger is sent.
- R8: With `use_rand` = 1, `ext_req` has no effect. A `rand_thresh` of 0 produces no triggers and no rejections.
- R9: With `use_rand` = 1, a request is raised in each cycle in which the internal 16-bit LFSR value is below `rand_thresh`. Random triggers carry type RAND_TYPE (4'hF by default).
- R10: After reset, `fe_trig` is 0, `host_valid` is 0 and `rej_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | Upstream trigger request, one request per cycle held high |
| ext_type | input | TYPE_W (4) | Type code logged with an external trigger |
| use_rand | input | 1 | Selects the internal random source instead of `ext_req` |
| rand_thresh | input | LFSR_W (16) | Random source threshold; a larger value gives a higher trigger rate |
| fe_busy | input | N_FE (4) | Busy lines from the front-end modules |
| fe_trig | output | N_FE (4) | Trigger pulse to every front-end module |
| host_rd | input | 1 | Removes the oldest queue entry |
| host_valid | output | 1 | Queue not empty |
| host_evt | output | EVT_W (16) | Event number of the oldest entry |
| host_type | output | TYPE_W (4) | Type code of the oldest entry |
| rej_count | output | REJ_W (16) | Number of refused requests, wrapping |

## Verification
The assertions assume that `use_rand` and `rand_thresh` are held at known values from reset onward. They also assume that `fe_busy` is driven at all times, never left unknown. The bench changes every input only at the falling edge and holds `fe_busy` at a defined mask throughout. It raises busy only after a pulse, releasing bits one at a time, except for one deliberate case with busy high while idle. It switches `use_rand` only while the block is idle or while it is recovering through the timeout.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRE  = 2'd1,
        ST_WRISE = 2'd2,
        ST_WCLR  = 2'd3
    } tg_state_e;

endpackage

// File: rtl/trig_lfsr_src.sv
module trig_lfsr_src #(
    parameter int          LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] thresh,
    output logic              hit
);

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
    } lfsr_t;

    lfsr_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sr = r_q.sr >> 1;
        if (r_q.sr[0]) begin
            r_d.sr = r_d.sr ^ TAPS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sr <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    // compare against threshold sets the mean request rate
    assign hit = (r_q.sr < thresh);

endmodule

// File: rtl/trig_busy_fsm.sv
module trig_busy_fsm
    import trig_pkg::*;
#(
    parameter int N_FE    = 4,
    parameter int TMO_CYC = 8,
    parameter int REJ_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [N_FE-1:0]  busy,
    input  logic             fifo_full,
    output logic             accept,
    output logic             fire,
    output logic [REJ_W-1:0] rej_count
);

    localparam int TMO_W = $clog2(TMO_CYC + 1);

    typedef struct packed {
        tg_state_e        st;
        logic [TMO_W-1:0] tmo;
        logic [REJ_W-1:0] rej;
    } fsm_t;

    fsm_t r_d, r_q;
    logic any_busy;
    logic rej_inc;

    assign any_busy = |busy;

    always_comb begin
        r_d     = r_q;
        accept  = 1'b0;
        rej_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (any_busy || fifo_full) begin
                        rej_inc = 1'b1;
                    end else begin
                        accept  = 1'b1;
                        r_d.st  = ST_FIRE;
                    end
                end
            end
            ST_FIRE: begin
                rej_inc = req;
                r_d.st  = ST_WRISE;
                r_d.tmo = '0;
            end
            ST_WRISE: begin
                rej_inc = req;
                if (any_busy) begin
                    r_d.st = ST_WCLR;
                end else if (r_q.tmo == TMO_W'(TMO_CYC - 1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.tmo = r_q.tmo + 1'b1;
                end
            end
            ST_WCLR: begin
                rej_inc = req;
                if (!any_busy) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (rej_inc) begin
            r_d.rej = r_q.rej + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.tmo <= '0;
            r_q.rej <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fire      = (r_q.st == ST_FIRE);
    assign rej_count = r_q.rej;

endmodule

// File: rtl/trig_info_fifo.sv
module trig_info_fifo #(
    parameter int DW    = 20,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t r_d, r_q;
    logic do_push, do_pop;

    assign do_push = push && (r_q.cnt != CW'(DEPTH));
    assign do_pop  = pop && (r_q.cnt != '0);

    always_comb begin
        r_d = r_q;
        if (do_push) begin
            r_d.mem[r_q.wr] = din;
            r_d.wr = (r_q.wr == AW'(DEPTH - 1)) ? '0 : r_q.wr + 1'b1;
        end
        if (do_pop) begin
            r_d.rd = (r_q.rd == AW'(DEPTH - 1)) ? '0 : r_q.rd + 1'b1;
        end
        r_d.cnt = r_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.mem <= '0;
            r_q.wr  <= '0;
            r_q.rd  <= '0;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout  = r_q.mem[r_q.rd];
    assign valid = (r_q.cnt != '0);
    assign full  = (r_q.cnt == CW'(DEPTH));
    assign count = r_q.cnt;

endmodule

// File: rtl/trig_fanout_gate.sv
module trig_fanout_gate #(
    parameter int                N_FE      = 4,
    parameter int                EVT_W     = 16,
    parameter int                TYPE_W    = 4,
    parameter int                DEPTH     = 4,
    parameter int                LFSR_W    = 16,
    parameter int                TMO_CYC   = 8,
    parameter int                REJ_W     = 16,
    parameter logic [TYPE_W-1:0] RAND_TYPE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req,
    input  logic [TYPE_W-1:0] ext_type,
    input  logic              use_rand,
    input  logic [LFSR_W-1:0] rand_thresh,
    input  logic [N_FE-1:0]   fe_busy,
    output logic [N_FE-1:0]   fe_trig,
    input  logic              host_rd,
    output logic              host_valid,
    output logic [EVT_W-1:0]  host_evt,
    output logic [TYPE_W-1:0] host_type,
    output logic [REJ_W-1:0]  rej_count
);

    localparam int ENT_W = EVT_W + TYPE_W;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [EVT_W-1:0] evt;
    } top_t;

    top_t r_d, r_q;

    logic              rand_hit;
    logic              req_sel;
    logic [TYPE_W-1:0] type_sel;
    logic              accept;
    logic              fire;
    logic              fifo_full;
    logic [ENT_W-1:0]  ent_in;
    logic [ENT_W-1:0]  ent_out;
    logic [CW-1:0]     fifo_cnt;

    trig_lfsr_src #(
        .LFSR_W (LFSR_W)
    ) u_rand (
        .clk    (clk),
        .rst_n  (rst_n),
        .thresh (rand_thresh),
        .hit    (rand_hit)
    );

    assign req_sel  = use_rand ? rand_hit : ext_req;
    assign type_sel = use_rand ? RAND_TYPE : ext_type;

    trig_busy_fsm #(
        .N_FE    (N_FE),
        .TMO_CYC (TMO_CYC),
        .REJ_W   (REJ_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_sel),
        .busy      (fe_busy),
        .fifo_full (fifo_full),
        .accept    (accept),
        .fire      (fire),
        .rej_count (rej_count)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.evt = r_q.evt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.evt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ent_in = {r_q.evt, type_sel};

    trig_info_fifo #(
        .DW    (ENT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (ent_in),
        .pop   (host_rd),
        .dout  (ent_out),
        .valid (host_valid),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    assign host_evt  = ent_out[ENT_W-1:TYPE_W];
    assign host_type = ent_out[TYPE_W-1:0];

    for (genvar g = 0; g < N_FE; g++) begin : g_fan
        assign fe_trig[g] = fire;
    end

endmodule

// File: rtl/trig_fanout_gate_chk.sv
module trig_fanout_gate_chk #(
    parameter int N_FE   = 4,
    parameter int LFSR_W = 16,
    parameter int REJ_W  = 16,
    parameter int DEPTH  = 4,
    parameter int CW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              use_rand,
    input logic [LFSR_W-1:0] rand_thresh,
    input logic [N_FE-1:0]   fe_busy,
    input logic [N_FE-1:0]   fe_trig,
    input logic [REJ_W-1:0]  rej_count,
    input logic [CW-1:0]     fifo_cnt
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_trig != '0) |=> (fe_trig == '0)); // R1

    AST_NO_TRIG_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_trig != '0) |-> ($past(fe_busy) == '0)); // R2

    AST_REJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_count == $past(rej_count)) || (rej_count == $past(rej_count) + 1'b1)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R7

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_trig != '0) |-> ($past(fifo_cnt) < CW'(DEPTH))); // R7

    AST_RAND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(use_rand) && ($past(rand_thresh) == '0)) |-> (fe_trig == '0)); // R8

endmodule

bind trig_fanout_gate trig_fanout_gate_chk #(
    .N_FE   (N_FE),
    .LFSR_W (LFSR_W),
    .REJ_W  (REJ_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .use_rand    (use_rand),
    .rand_thresh (rand_thresh),
    .fe_busy     (fe_busy),
    .fe_trig     (fe_trig),
    .rej_count   (rej_count),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/tb_trig_fanout_gate.sv
`timescale 1ns/1ps
module tb_trig_fanout_gate;

    localparam int TMO   = 8;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_req = 1'b0;
    logic [3:0]  ext_type = '0;
    logic        use_rand = 1'b0;
    logic [15:0] rand_thresh = '0;
    logic [3:0]  fe_busy = '0;
    logic [3:0]  fe_trig;
    logic        host_rd = 1'b0;
    logic        host_valid;
    logic [15:0] host_evt;
    logic [3:0]  host_type;
    logic [15:0] rej_count;

    int n_chk = 0;
    int n_fail = 0;
    int trig_cnt = 0;
    bit prev_trig = 1'b0;
    bit done = 1'b0;
    int exp_evt = 0;
    int exp_rej = 0;

    always #2 clk = ~clk;

    trig_fanout_gate dut (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_type(ext_type),
        .use_rand(use_rand), .rand_thresh(rand_thresh), .fe_busy(fe_busy),
        .fe_trig(fe_trig), .host_rd(host_rd), .host_valid(host_valid),
        .host_evt(host_evt), .host_type(host_type), .rej_count(rej_count)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // R1 monitor: pulse is all-ones or zero, never two cycles in a row
    always @(negedge clk) begin
        if (rst_n && fe_trig != 4'h0) begin
            trig_cnt++;
            if (fe_trig != 4'hF || prev_trig) begin
                n_fail++;
                $display("FAIL R1 shape actual=%0h expected=f single", fe_trig);
            end
        end
        prev_trig = (fe_trig != 4'h0);
    end

    task automatic pulse_req(input logic [3:0] t);
        ext_type = t;
        ext_req  = 1'b1;
        @(negedge clk);
        ext_req  = 1'b0;
    endtask

    task automatic pop_chk(input string rq, input int evt, input int typ);
        chk({rq, " valid"}, int'(host_valid), 1);
        chk({rq, " evt"}, int'(host_evt), evt);
        chk({rq, " type"}, int'(host_type), typ);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0;
        int got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk("R10 fe_trig", int'(fe_trig), 0);
        chk("R10 host_valid", int'(host_valid), 0);
        chk("R10 rej_count", int'(rej_count), 0);

        // R2: busy high while idle blocks
        fe_busy = 4'h2;
        t0 = trig_cnt;
        pulse_req(4'h1);
        exp_rej++;
        chk("R2 idle busy no trig", int'(fe_trig), 0);
        chk("R5 idle busy rej", int'(rej_count), exp_rej);
        fe_busy = 4'h0;
        @(negedge clk);
        chk("R2 idle busy count", trig_cnt, t0);

        // sweep every non-zero busy mask
        for (int m = 1; m < 16; m++) begin
            t0 = trig_cnt;
            pulse_req(m[3:0]);
            chk("R1 fan-out", int'(fe_trig), 15);
            pop_chk("R3 R4 entry", exp_evt, m);
            exp_evt++;
            fe_busy = m[3:0];
            for (int i = 0; i < 4; i++) begin
                if (m[i]) begin
                    pulse_req(4'h0);
                    exp_rej++;
                    fe_busy[i] = 1'b0;
                end
            end
            @(negedge clk);
            chk("R2 held while busy", trig_cnt, t0 + 1);
            chk("R5 rej per mask", int'(rej_count), exp_rej);
        end

        // R6 timeout when busy never rises
        pulse_req(4'h3);
        repeat (TMO) @(negedge clk);
        t0 = trig_cnt;
        pulse_req(4'h4);
        exp_rej++;
        chk("R6 refused at limit", trig_cnt, t0);
        pulse_req(4'h5);
        chk("R6 accepted after limit", int'(fe_trig), 15);
        chk("R5 timeout rej", int'(rej_count), exp_rej);
        pop_chk("R4 order a", exp_evt, 3);
        pop_chk("R4 order b", exp_evt + 1, 5);
        exp_evt += 2;
        chk("R4 empty", int'(host_valid), 0);
        repeat (TMO + 2) @(negedge clk);

        // R7 full queue blocks
        for (int k = 0; k < DEPTH; k++) begin
            pulse_req(k[3:0]);
            repeat (TMO + 1) @(negedge clk);
        end
        t0 = trig_cnt;
        pulse_req(4'h9);
        exp_rej++;
        chk("R7 no trig when full", int'(fe_trig), 0);
        chk("R7 rej when full", int'(rej_count), exp_rej);
        chk("R7 count", trig_cnt, t0);
        for (int k = 0; k < DEPTH; k++) begin
            pop_chk("R7 R3 drain", exp_evt + k, k);
        end
        exp_evt += DEPTH;
        pulse_req(4'h6);
        chk("R7 accepts after drain", int'(fe_trig), 15);
        pop_chk("R3 after drain", exp_evt, 6);
        exp_evt++;
        repeat (TMO + 2) @(negedge clk);

        // R8 random source with zero threshold ignores ext_req
        use_rand = 1'b1;
        rand_thresh = 16'h0000;
        t0 = trig_cnt;
        ext_req = 1'b1;
        repeat (60) @(negedge clk);
        ext_req = 1'b0;
        chk("R8 no trig", trig_cnt, t0);
        chk("R8 no rej", int'(rej_count), exp_rej);
        chk("R8 queue empty", int'(host_valid), 0);

        // R9 random triggers at maximal threshold
        rand_thresh = 16'hFFFF;
        host_rd = 1'b1;
        got = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (host_valid) begin
                chk("R9 R3 rand evt", int'(host_evt), exp_evt);
                chk("R9 rand type", int'(host_type), 15);
                exp_evt++;
                got++;
            end
        end
        use_rand = 1'b0;
        rand_thresh = 16'h0000;
        repeat (TMO + 3) @(negedge clk);
        while (host_valid) begin
            chk("R9 R3 rand tail", int'(host_evt), exp_evt);
            exp_evt++;
            got++;
            @(negedge clk);
        end
        host_rd = 1'b0;
        chk("R9 rand trig seen", int'(got >= 10), 1);
        chk("R9 trig count", trig_cnt, exp_evt);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule